// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the processor-side end of a shared address/data bus. One set of output lines carries the full address at the start of a transfer and then carries write data, or is released so a device can return read data. A caller presents a request with an address, write data, a direction flag, a memory-or-I/O flag and a two-bit segment code. The block accepts the request, steps through the bus states T1, T2, T3, optional wait states Tw and T4, and drives the strobes that external address latches and data buffers need.

In T1 a latch-enable pulse marks the address. The direction and memory/I/O select lines are already valid in that state, so buffers can be steered before data moves. From T2 on, the segment code takes the place of the upper address bits. A read or write strobe covers T2, T3 and every wait state. A slow device holds the ready input low to stretch the cycle. Read data is captured on the edge that ends the last T3 or Tw state and is presented with a one-state done pulse in T4. A request that is pending during T4 starts its T1 straight away. Otherwise the block goes idle.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_taken` is high in any state where `req_valid` is high and the block is idle or in T4. The state after such a cycle is T1, which is the only state with `ale` high.
- R2: `ale` is high in T1 only. In T1, `bus_ad_out` carries the full latched address and `bus_oe_hi` and `bus_oe_lo` are both high.
- R3: `dt_r` is high for a write and low for a read in every state from T1 through T4.
- R4: `m_io` is high for a memory transfer and low for an I/O transfer in every state from T1 through T4.
- R5: From T2 through T4, `bus_ad_out[19:16]` is the segment code zero-extended, with the code in bits 17:16 and bits 19:18 at 0. The codes are 00 = extra, 01 = stack, 10 = code and 11 = data.
- R6: From T2 through T4 on a read, `bus_oe_lo` is low, so the data half of the bus is released. On a write, `bus_oe_lo` is high and `bus_ad_out[15:0]` carries the write data.
- R7: `rd_stb` (read) or `wr_stb` (write) is high in T2, T3 and every Tw state. Both are low in T1, T4 and idle, and the two are never high together.
- R8: `rdy` is sampled only at the end of T3 and at the end of each Tw. Each low sample adds one Tw, so a transfer lasts 4 plus that number of states.
- R9: For a read, `bus_ad_in` is captured at the edge that ends the final T3 or Tw state and is shown on `rdata` in T4. A write leaves `rdata` unchanged.
- R10: `done` is high for exactly one state, T4, of each transfer.
- R11: While `rst` is high at a clock edge, the block returns to idle. After that edge `ale`, both strobes, `done`, `bus_oe_hi` and `bus_oe_lo` are all low.
- R12: If no request is pending in T4, the next state is idle, with the bus released and `ale` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_seg | input | 2 | Segment code |
| req_taken | output | 1 | Request accepted this state |
| rdy | input | 1 | Device ready |
| bus_ad_out | output | 20 | Value driven on shared lines |
| bus_ad_in | input | 16 | Value seen on data half of the lines |
| bus_oe_hi | output | 1 | Drive enable, upper address/status field |
| bus_oe_lo | output | 1 | Drive enable, address/data half |
| ale | output | 1 | Address latch enable |
| dt_r | output | 1 | Buffer direction, 1 = transmit |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | Transfer complete pulse (T4) |
| rdata | output | 16 | Captured read data |

## Verification
The hardest case to reach is a read whose data is taken after several wait states. The capture must use the value present at the last ready sample, not the one seen when T3 began. The bench drives the inverse of the expected data on the bus while ready is low and the true value only in the state where ready rises. A wrong capture edge then shows up as a corrupted `rdata`. Back-to-back requests raised during T4 and a reset asserted in the middle of a transfer are driven as directed sequences on top of the full sweep of direction, space, segment and wait count.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;

  localparam int SEG_W = 2;

  // States in which the read or write strobe is active
  function automatic logic strobe_phase(bus_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // States whose closing edge samples ready
  function automatic logic ready_phase(bus_state_e s);
    return (s == ST_T3) || (s == ST_TW);
  endfunction

  // States in which a new request may be accepted
  function automatic logic accept_phase(bus_state_e s);
    return (s == ST_IDLE) || (s == ST_T4);
  endfunction

  // Any state belonging to a transfer
  function automatic logic active_phase(bus_state_e s);
    return s != ST_IDLE;
  endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       rdy,
  output bus_state_e st,
  output logic       take,
  output logic       capture
);

  bus_state_e nxt;

  assign take    = req_valid && accept_phase(st);
  assign capture = ready_phase(st) && rdy;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: nxt = req_valid ? ST_T1 : ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = rdy ? ST_T4 : ST_TW;
      ST_T4:   nxt = req_valid ? ST_T1 : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

endmodule

// File: rtl/mbs_req_reg.sv
module mbs_req_reg
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic              in_mem,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              write_q,
  output logic              mem_q,
  output logic [SEG_W-1:0]  seg_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      seg_q   <= '0;
    end else if (load) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      write_q <= in_write;
      mem_q   <= in_mem;
      seg_q   <= in_seg;
    end
  end

  // Read data is taken on the edge that closes the final T3/Tw state
  always_ff @(posedge clk) begin
    if (rst)                   rdata_q <= '0;
    else if (capture && !write_q) rdata_q <= bus_in;
  end

endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  bus_state_e        st,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              write_q,
  input  logic              mem_q,
  input  logic [SEG_W-1:0]  seg_q,
  output logic [ADDR_W-1:0] bus_ad,
  output logic              oe_hi,
  output logic              oe_lo,
  output logic              ale,
  output logic              dt_r,
  output logic              m_io,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done
);

  localparam int UP_W = ADDR_W - DATA_W;

  logic active;
  logic in_t1;

  assign active = active_phase(st);
  assign in_t1  = (st == ST_T1);

  assign ale    = in_t1;
  assign done   = (st == ST_T4);
  assign dt_r   = active && write_q;
  assign m_io   = active && mem_q;
  assign rd_stb = strobe_phase(st) && !write_q;
  assign wr_stb = strobe_phase(st) &&  write_q;
  assign oe_hi  = active;
  assign oe_lo  = in_t1 || (active && write_q);

  always_comb begin
    if (!active)   bus_ad = '0;
    else if (in_t1) bus_ad = addr_q;
    else           bus_ad = {UP_W'(seg_q), (write_q ? wdata_q : {DATA_W{1'b0}})};
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [1:0]        req_seg,
  output logic              req_taken,
  input  logic              rdy,
  output logic [ADDR_W-1:0] bus_ad_out,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic              bus_oe_hi,
  output logic              bus_oe_lo,
  output logic              ale,
  output logic              dt_r,
  output logic              m_io,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  bus_state_e        st;
  logic              capture;
  logic              ready_window;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              mem_q;
  logic [SEG_W-1:0]  seg_q;

  assign ready_window = ready_phase(st);

  mbs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rdy       (rdy),
    .st        (st),
    .take      (req_taken),
    .capture   (capture)
  );

  mbs_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk      (clk),
    .rst      (rst),
    .load     (req_taken),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_write (req_write),
    .in_mem   (req_mem),
    .in_seg   (req_seg),
    .capture  (capture),
    .bus_in   (bus_ad_in),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .write_q  (write_q),
    .mem_q    (mem_q),
    .seg_q    (seg_q),
    .rdata_q  (rdata)
  );

  mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .st      (st),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .write_q (write_q),
    .mem_q   (mem_q),
    .seg_q   (seg_q),
    .bus_ad  (bus_ad_out),
    .oe_hi   (bus_oe_hi),
    .oe_lo   (bus_oe_lo),
    .ale     (ale),
    .dt_r    (dt_r),
    .m_io    (m_io),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .done    (done)
  );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst,
  input logic rdy,
  input logic req_taken,
  input logic ale,
  input logic rd_stb,
  input logic wr_stb,
  input logic done,
  input logic bus_oe_hi,
  input logic bus_oe_lo,
  input logic ready_window
);

  p_take_opens_t1_r1: assert property (@(posedge clk) disable iff (rst)
    req_taken |=> ale);

  p_ale_one_state_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && (rd_stb || wr_stb)));

  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> !bus_oe_lo);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  p_wait_on_low_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_window && !rdy) |=> (ready_window && !done));

  p_ready_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_window && rdy) |=> (done && !rd_stb && !wr_stb));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ale && !rd_stb && !wr_stb && !done && !bus_oe_hi && !bus_oe_lo));

endmodule

bind mux_bus_seq mbs_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .rdy          (rdy),
  .req_taken    (req_taken),
  .ale          (ale),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb),
  .done         (done),
  .bus_oe_hi    (bus_oe_hi),
  .bus_oe_lo    (bus_oe_lo),
  .ready_window (ready_window)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_mem = 1'b0;
  logic [1:0]  req_seg = '0;
  logic        req_taken;
  logic        rdy = 1'b0;
  logic [19:0] bus_ad_out;
  logic [15:0] bus_ad_in = '0;
  logic        bus_oe_hi, bus_oe_lo, ale, dt_r, m_io, rd_stb, wr_stb, done;
  logic [15:0] rdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_mem(req_mem),
    .req_seg(req_seg), .req_taken(req_taken), .rdy(rdy),
    .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_oe_hi(bus_oe_hi),
    .bus_oe_lo(bus_oe_lo), .ale(ale), .dt_r(dt_r), .m_io(m_io),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done), .rdata(rdata)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " strobes"}, {rd_stb, wr_stb}, 0);
    chk({tag, " done"}, done, 0);
    chk({tag, " oe"}, {bus_oe_hi, bus_oe_lo}, 0);
  endtask

  // Called at a negedge when the block is idle or in T4. Returns at the
  // negedge of T4 (stay=1) or of the following idle state (stay=0).
  task automatic xfer(input int idx, input logic [1:0] seg, input logic wr,
                      input logic mem, input int nwait, input logic stay);
    logic [19:0] a;
    logic [15:0] wd;
    logic [15:0] rv;
    a  = 20'h12345 ^ (idx * 20'h0F0F1);
    wd = 16'hA5C3 + idx * 16'h1357;
    rv = 16'h3C00 ^ (idx * 16'h0101);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr;
    req_mem = mem; req_seg = seg; rdy = 1'b0; bus_ad_in = ~rv;
    #1 chk("R1 req_taken", req_taken, 1);
    @(negedge clk);                         // T1
    chk("R2 ale in T1", ale, 1);
    chk("R2 address", bus_ad_out, a);
    chk("R2 oe in T1", {bus_oe_hi, bus_oe_lo}, 2'b11);
    chk("R3 dt_r T1", dt_r, wr);
    chk("R4 m_io T1", m_io, mem);
    chk("R7 strobes T1", {rd_stb, wr_stb}, 0);
    req_valid = 1'b0;
    @(negedge clk);                         // T2
    chk("R2 ale off T2", ale, 0);
    chk("R5 status T2", bus_ad_out[19:16], {2'b00, seg});
    chk("R7 strobes T2", {rd_stb, wr_stb}, {!wr, wr});
    chk("R6 oe_lo T2", bus_oe_lo, wr);
    if (wr) chk("R6 wdata T2", bus_ad_out[15:0], wd);
    chk("R3 dt_r T2", dt_r, wr);
    chk("R4 m_io T2", m_io, mem);
    @(negedge clk);                         // T3
    chk("R7 strobes T3", {rd_stb, wr_stb}, {!wr, wr});
    chk("R10 done T3", done, 0);
    rdy = (nwait == 0);
    bus_ad_in = rdy ? rv : ~rv;
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);                       // Tw
      chk("R8 strobes Tw", {rd_stb, wr_stb}, {!wr, wr});
      chk("R8 done Tw", done, 0);
      chk("R6 oe_lo Tw", bus_oe_lo, wr);
      rdy = (w == nwait - 1);
      bus_ad_in = rdy ? rv : ~rv;
    end
    @(negedge clk);                         // T4
    chk("R10 done T4", done, 1);
    chk("R8 length", done, 1);
    chk("R7 strobes T4", {rd_stb, wr_stb}, 0);
    chk("R9 rdata", rdata, wr ? last_rd : rv);
    chk("R5 status T4", bus_ad_out[19:16], {2'b00, seg});
    chk("R3 dt_r T4", dt_r, wr);
    chk("R4 m_io T4", m_io, mem);
    if (!wr) last_rd = rv;
    rdy = 1'b0;
    bus_ad_in = 16'h0000;
    if (!stay) begin
      @(negedge clk);                       // idle
      chk_idle("R12 idle");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    chk_idle("R11 reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R11 after reset");
    chk("R1 no request", req_taken, 0);

    // Full sweep: segment, direction, space, wait count
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 2; m++)
          for (int nw = 0; nw < 4; nw++) begin
            xfer(idx, 2'(s), w[0], m[0], nw, 1'b0);
            idx++;
          end

    // Back-to-back transfers launched from T4 (R1)
    xfer(idx, 2'b11, 1'b0, 1'b1, 2, 1'b1); idx++;
    xfer(idx, 2'b10, 1'b1, 1'b0, 0, 1'b1); idx++;
    xfer(idx, 2'b01, 1'b0, 1'b0, 5, 1'b1); idx++;
    xfer(idx, 2'b00, 1'b0, 1'b1, 1, 1'b0); idx++;

    // Reset in the middle of a read (R11)
    req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1; req_seg = 2'b01;
    req_addr = 20'hABCDE;
    @(negedge clk);                         // T1
    req_valid = 1'b0;
    @(negedge clk);                         // T2
    chk("R11 strobe before reset", rd_stb, 1);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R11 mid-cycle reset");
    chk("R11 rdata cleared", rdata, 0);
    rst = 1'b0;
    last_rd = '0;
    @(negedge clk);
    chk_idle("R11 stays idle");
    xfer(idx, 2'b10, 1'b0, 1'b0, 3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule